// File: doc/BRIEF.md
# Descriptor-Driven DMA Sequencer

This block is the control sequencer of a single-channel memory-to-memory copy engine. Software writes a descriptor: source address, destination address, byte count and a direction bit. Software then raises a one-cycle set strobe, which marks the descriptor as ready. The sequencer waits for that ready flag. It copies the descriptor into its own working registers and clears the flag, so the same descriptor is never run twice. It then runs a fill stream and a drain stream at the same time. The fill stream reads beats from the source into an internal buffer. The drain stream writes those beats to the destination.

There are two bus ports: a bus-matrix port and a memory-bridge port. The direction bit decides which port carries the reads and which carries the writes. Each port uses a simple protocol. The port holds a request with an address and a write flag. The target answers with a one-cycle done pulse or a one-cycle error pulse while the request is high. The sequencer declares success only after every byte has been written to the destination. It records the outcome in its status bits. A debug view shows the current state and the number of bytes still to be written.

Top module: `dma_seq_top`

## Requirements
- R1: While reset is held, the state is idle, no port request is raised, and the ready flag and the done, error and busy bits all read 0.
- R2: A pulse on `desc_set_i` raises `desc_valid_o` on the next cycle. Until that flag is raised, the sequencer stays idle and issues no request.
- R3: The sequencer accepts a ready descriptor in the same clock edge that takes it into the load state. At that edge it copies all the descriptor fields, clears the ready flag, clears done and error, and sets busy. Later changes on the descriptor inputs have no effect on the running transfer.
- R4: When the direction bit is 1, reads (`*_we_o`=0) appear only on the memory-bridge port and writes (`*_we_o`=1) only on the bus-matrix port.
- R5: When the direction bit is 0, reads appear only on the bus-matrix port and writes only on the memory-bridge port.
- R6: Read beat k uses address source+k·BEAT_BYTES and write beat k uses address destination+k·BEAT_BYTES. Each stream issues exactly ceil(count/BEAT_BYTES) beats, and the last beat may be partial.
- R7: The number of reads completed is never more than the number of writes completed plus BUF_BEATS. A write is never requested unless a read beat is waiting in the buffer.
- R8: The state is encoded as idle=0, load=1, run=2, status=3, error=4. Done is set, and busy cleared, only after the final write beat. The path is run → status → idle.
- R9: An error pulse on either port during run sends the sequencer to the error state. No request is raised after that. Error is set, done stays 0, and busy clears on the return to idle.
- R10: A descriptor with a byte count of 0 goes from load to error without any port request.
- R11: In any cycle that follows a clock edge at which `pause_i` was 1, no request is raised. Requests resume after `pause_i` falls.
- R12: `dbg_remain_o` equals the byte count minus BEAT_BYTES times the number of completed writes, floored at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_set_i | input | 1 | One-cycle strobe that marks the descriptor ready |
| desc_src_i | input | ADDR_W | Source start address |
| desc_dst_i | input | ADDR_W | Destination start address |
| desc_len_i | input | LEN_W | Byte count |
| desc_dir_i | input | 1 | 1: read bridge and write matrix; 0: the reverse |
| pause_i | input | 1 | Holds off new requests while high |
| desc_valid_o | output | 1 | Descriptor-ready flag |
| mtx_req_o | output | 1 | Bus-matrix port request |
| mtx_we_o | output | 1 | Bus-matrix port write (1) or read (0) |
| mtx_addr_o | output | ADDR_W | Bus-matrix port address |
| mtx_done_i | input | 1 | Bus-matrix beat completed |
| mtx_err_i | input | 1 | Bus-matrix error response |
| brg_req_o | output | 1 | Memory-bridge port request |
| brg_we_o | output | 1 | Memory-bridge port write (1) or read (0) |
| brg_addr_o | output | ADDR_W | Memory-bridge port address |
| brg_done_i | input | 1 | Memory-bridge beat completed |
| brg_err_i | input | 1 | Memory-bridge error response |
| stat_done_o | output | 1 | Status: last transfer completed |
| stat_err_o | output | 1 | Status: last transfer failed |
| stat_busy_o | output | 1 | Status: transfer in progress |
| dbg_state_o | output | 3 | Debug: state encoding |
| dbg_remain_o | output | LEN_W | Debug: bytes not yet written |

## Verification
The bench builds the block with BUF_BEATS=2, BEAT_BYTES=4 and LEN_W=10. The two-beat buffer makes the fill stream hit the full limit often, because the target model answers each port at random. With four-byte beats, byte counts that are not multiples of the beat size exercise the partial last beat. The ten-bit count keeps each transfer short, so the run covers many random descriptors in both directions, including error and pause cases.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOAD   = 3'd1,
        ST_RUN    = 3'd2,
        ST_STATUS = 3'd3,
        ST_ERROR  = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       valid;
        logic       dir;
        logic       pause;
        logic       done;
        logic       err;
        logic       busy;
    } ctrl_regs_t;

endpackage

// File: rtl/dma_seq_chan.sv
module dma_seq_chan #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int BEAT_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              enable_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LEN_W-1:0]  remain_o,
    output logic              empty_o
);

    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(BEAT_BYTES);
    localparam logic [LEN_W-1:0]  LEN_STEP  = LEN_W'(BEAT_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  remain;
    } chan_regs_t;

    chan_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.addr   = start_addr_i;
            r_d.remain = len_i;
        end else if (ack_i && req_o) begin
            r_d.addr   = r_q.addr + ADDR_STEP;
            r_d.remain = (r_q.remain > LEN_STEP) ? (r_q.remain - LEN_STEP) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign empty_o  = (r_q.remain == '0);
    assign req_o    = enable_i && !empty_o;
    assign addr_o   = r_q.addr;
    assign remain_o = r_q.remain;

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && req_o && !load_i) |=> (addr_o == $past(addr_o) + ADDR_STEP));

endmodule

// File: rtl/dma_seq_occ.sv
module dma_seq_occ #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    input  logic dec_i,
    output logic room_o,
    output logic avail_o
);

    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [OCC_W-1:0] OCC_MAX = OCC_W'(DEPTH);

    logic [OCC_W-1:0] occ_d, occ_q;

    always_comb begin
        occ_d = occ_q;
        if (clr_i)               occ_d = '0;
        else if (inc_i && !dec_i) occ_d = occ_q + 1'b1;
        else if (dec_i && !inc_i) occ_d = occ_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end

    assign room_o  = (occ_q < OCC_MAX);
    assign avail_o = (occ_q != '0);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OCC_MAX);
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i && !clr_i) |-> (occ_q != '0));

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       desc_set_i,
    input  logic       desc_dir_i,
    input  logic       pause_i,
    input  logic       drain_empty_i,
    input  logic       run_err_i,
    output seq_state_e state_o,
    output logic       load_o,
    output logic       run_o,
    output logic       dir_o,
    output logic       valid_o,
    output logic       done_o,
    output logic       err_o,
    output logic       busy_o
);

    ctrl_regs_t r_d, r_q;
    logic       load_d;

    always_comb begin
        r_d    = r_q;
        load_d = 1'b0;
        r_d.pause = pause_i;
        if (desc_set_i) r_d.valid = 1'b1;
        unique case (r_q.state)
            ST_IDLE: begin
                if (r_q.valid) begin
                    load_d    = 1'b1;
                    r_d.state = ST_LOAD;
                    r_d.valid = desc_set_i;
                    r_d.dir   = desc_dir_i;
                    r_d.done  = 1'b0;
                    r_d.err   = 1'b0;
                    r_d.busy  = 1'b1;
                end
            end
            ST_LOAD: begin
                r_d.state = drain_empty_i ? ST_ERROR : ST_RUN;
            end
            ST_RUN: begin
                if (run_err_i)          r_d.state = ST_ERROR;
                else if (drain_empty_i) r_d.state = ST_STATUS;
            end
            ST_STATUS: begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
                r_d.busy  = 1'b0;
            end
            ST_ERROR: begin
                r_d.state = ST_IDLE;
                r_d.err   = 1'b1;
                r_d.busy  = 1'b0;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;
    assign load_o  = load_d;
    assign run_o   = (r_q.state == ST_RUN) && !r_q.pause;
    assign dir_o   = r_q.dir;
    assign valid_o = r_q.valid;
    assign done_o  = r_q.done;
    assign err_o   = r_q.err;
    assign busy_o  = r_q.busy;

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && !r_q.valid) |=> (r_q.state == ST_IDLE));
    p_load_clears_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && r_q.valid && !desc_set_i) |=> (r_q.state == ST_LOAD && !r_q.valid && r_q.busy));
    p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_LOAD && drain_empty_i) |=> (r_q.state == ST_ERROR));
    p_run_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN && drain_empty_i && !run_err_i) |=> (r_q.state == ST_STATUS));

endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int BEAT_BYTES = 4,
    parameter int BUF_BEATS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_set_i,
    input  logic [ADDR_W-1:0] desc_src_i,
    input  logic [ADDR_W-1:0] desc_dst_i,
    input  logic [LEN_W-1:0]  desc_len_i,
    input  logic              desc_dir_i,
    input  logic              pause_i,
    output logic              desc_valid_o,
    output logic              mtx_req_o,
    output logic              mtx_we_o,
    output logic [ADDR_W-1:0] mtx_addr_o,
    input  logic              mtx_done_i,
    input  logic              mtx_err_i,
    output logic              brg_req_o,
    output logic              brg_we_o,
    output logic [ADDR_W-1:0] brg_addr_o,
    input  logic              brg_done_i,
    input  logic              brg_err_i,
    output logic              stat_done_o,
    output logic              stat_err_o,
    output logic              stat_busy_o,
    output logic [2:0]        dbg_state_o,
    output logic [LEN_W-1:0]  dbg_remain_o
);

    seq_state_e        state;
    logic              load, run, dir;
    logic              room, avail;
    logic              fill_req, drain_req, fill_ack, drain_ack;
    logic              fill_empty, drain_empty, run_err;
    logic [ADDR_W-1:0] fill_addr, drain_addr;
    logic [LEN_W-1:0]  fill_remain, drain_remain;

    dma_seq_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .desc_set_i    (desc_set_i),
        .desc_dir_i    (desc_dir_i),
        .pause_i       (pause_i),
        .drain_empty_i (drain_empty),
        .run_err_i     (run_err),
        .state_o       (state),
        .load_o        (load),
        .run_o         (run),
        .dir_o         (dir),
        .valid_o       (desc_valid_o),
        .done_o        (stat_done_o),
        .err_o         (stat_err_o),
        .busy_o        (stat_busy_o)
    );

    dma_seq_chan #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)) u_fill (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .start_addr_i (desc_src_i),
        .len_i        (desc_len_i),
        .enable_i     (run && room),
        .ack_i        (fill_ack),
        .req_o        (fill_req),
        .addr_o       (fill_addr),
        .remain_o     (fill_remain),
        .empty_o      (fill_empty)
    );

    dma_seq_chan #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)) u_drain (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .start_addr_i (desc_dst_i),
        .len_i        (desc_len_i),
        .enable_i     (run && avail),
        .ack_i        (drain_ack),
        .req_o        (drain_req),
        .addr_o       (drain_addr),
        .remain_o     (drain_remain),
        .empty_o      (drain_empty)
    );

    dma_seq_occ #(.DEPTH(BUF_BEATS)) u_occ (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (load),
        .inc_i   (fill_ack),
        .dec_i   (drain_ack),
        .room_o  (room),
        .avail_o (avail)
    );

    // Direction 1: fill on the bridge port, drain on the matrix port.
    always_comb begin
        if (dir) begin
            brg_req_o  = fill_req;
            brg_we_o   = 1'b0;
            brg_addr_o = fill_addr;
            mtx_req_o  = drain_req;
            mtx_we_o   = 1'b1;
            mtx_addr_o = drain_addr;
            fill_ack   = fill_req && brg_done_i;
            drain_ack  = drain_req && mtx_done_i;
        end else begin
            mtx_req_o  = fill_req;
            mtx_we_o   = 1'b0;
            mtx_addr_o = fill_addr;
            brg_req_o  = drain_req;
            brg_we_o   = 1'b1;
            brg_addr_o = drain_addr;
            fill_ack   = fill_req && mtx_done_i;
            drain_ack  = drain_req && brg_done_i;
        end
    end

    assign run_err      = (mtx_req_o && mtx_err_i) || (brg_req_o && brg_err_i);
    assign dbg_state_o  = state;
    assign dbg_remain_o = drain_remain;

    p_quiet_outside_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |-> (!mtx_req_o && !brg_req_o));
    p_err_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && run_err) |=> (state == ST_ERROR));
    p_pause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pause_i |=> (!mtx_req_o && !brg_req_o));
    p_done_drained_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_done_o) |-> (dbg_remain_o == '0));
    p_fill_not_behind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (fill_remain <= drain_remain || fill_empty));

endmodule

// File: tb/dma_seq_top_test.sv
module dma_seq_top_test;

    localparam int AW  = 32;
    localparam int LW  = 10;
    localparam int BB  = 4;
    localparam int BUF = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          desc_set_i = 1'b0;
    logic [AW-1:0] desc_src_i = '0;
    logic [AW-1:0] desc_dst_i = '0;
    logic [LW-1:0] desc_len_i = '0;
    logic          desc_dir_i = 1'b0;
    logic          pause_i = 1'b0;
    logic          mtx_done_i = 1'b0, mtx_err_i = 1'b0;
    logic          brg_done_i = 1'b0, brg_err_i = 1'b0;
    logic          desc_valid_o, mtx_req_o, mtx_we_o, brg_req_o, brg_we_o;
    logic [AW-1:0] mtx_addr_o, brg_addr_o;
    logic          stat_done_o, stat_err_o, stat_busy_o;
    logic [2:0]    dbg_state_o;
    logic [LW-1:0] dbg_remain_o;

    always #4 clk = ~clk;

    dma_seq_top #(.ADDR_W(AW), .LEN_W(LW), .BEAT_BYTES(BB), .BUF_BEATS(BUF)) uut (
        .clk(clk), .rst_n(rst_n), .desc_set_i(desc_set_i), .desc_src_i(desc_src_i),
        .desc_dst_i(desc_dst_i), .desc_len_i(desc_len_i), .desc_dir_i(desc_dir_i),
        .pause_i(pause_i), .desc_valid_o(desc_valid_o),
        .mtx_req_o(mtx_req_o), .mtx_we_o(mtx_we_o), .mtx_addr_o(mtx_addr_o),
        .mtx_done_i(mtx_done_i), .mtx_err_i(mtx_err_i),
        .brg_req_o(brg_req_o), .brg_we_o(brg_we_o), .brg_addr_o(brg_addr_o),
        .brg_done_i(brg_done_i), .brg_err_i(brg_err_i),
        .stat_done_o(stat_done_o), .stat_err_o(stat_err_o), .stat_busy_o(stat_busy_o),
        .dbg_state_o(dbg_state_o), .dbg_remain_o(dbg_remain_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int beats_of(input int len);
        return (len + BB - 1) / BB;
    endfunction

    function automatic int remain_of(input int len, input int n);
        int r;
        r = len - n * BB;
        return (r < 0) ? 0 : r;
    endfunction

    // Target model and monitor state
    bit          mon_on = 0;
    bit          quiet = 0;
    int          fills = 0, drains = 0, exp_len = 0, err_at = -1;
    int          pause_from = -1, run_cyc = 0;
    logic [31:0] exp_src = '0, exp_dst = '0;
    bit          exp_dir = 0;

    task automatic serve(input bit is_brg, input logic we, input logic [31:0] addr,
                         input int f0, input int d0, output bit dn, output bit er);
        dn = 0;
        er = 0;
        if (!we) begin
            chk(is_brg == exp_dir, exp_dir ? "R4 read on bridge port" : "R5 read on matrix port",
                is_brg, exp_dir);
            chk(f0 < beats_of(exp_len), "R6 read beat count", f0, beats_of(exp_len));
            chk(f0 - d0 < BUF, "R7 fill within buffer", f0 - d0, BUF - 1);
            chk(addr == exp_src + 32'(f0 * BB), "R6 read address", addr, exp_src + 32'(f0 * BB));
            if ($urandom % 2 == 0) begin
                dn = 1;
                fills++;
            end
        end else begin
            chk(is_brg == !exp_dir, exp_dir ? "R4 write on matrix port" : "R5 write on bridge port",
                is_brg, !exp_dir);
            chk(d0 < f0, "R7 write only buffered beats", d0, f0 - 1);
            chk(addr == exp_dst + 32'(d0 * BB), "R6 write address", addr, exp_dst + 32'(d0 * BB));
            if ($urandom % 2 == 0) begin
                if (d0 == err_at) er = 1;
                else begin
                    dn = 1;
                    drains++;
                end
            end
        end
    endtask

    always @(negedge clk) begin
        bit md, me, bd, be;
        int f0, d0;
        md = 0; me = 0; bd = 0; be = 0;
        if (rst_n && mon_on) begin
            run_cyc++;
            f0 = fills;
            d0 = drains;
            if (quiet || dbg_state_o != 3'd2)
                chk(!mtx_req_o && !brg_req_o, "R9 no request outside run", mtx_req_o | brg_req_o, 0);
            if (pause_i && dbg_state_o == 3'd2)
                chk(!mtx_req_o && !brg_req_o, "R11 no request while paused", mtx_req_o | brg_req_o, 0);
            if (dbg_state_o >= 3'd2 && dbg_state_o <= 3'd4)
                chk(int'(dbg_remain_o) == remain_of(exp_len, d0), "R12 remaining bytes",
                    dbg_remain_o, remain_of(exp_len, d0));
            if (mtx_req_o) serve(1'b0, mtx_we_o, mtx_addr_o, f0, d0, md, me);
            if (brg_req_o) serve(1'b1, brg_we_o, brg_addr_o, f0, d0, bd, be);
            if (me || be) quiet = 1;
        end
        mtx_done_i = md; mtx_err_i = me;
        brg_done_i = bd; brg_err_i = be;
        pause_i = (pause_from >= 0) && (run_cyc >= pause_from) && (run_cyc < pause_from + 15);
    end

    task automatic run_desc(input logic [31:0] s, input logic [31:0] d, input int len,
                            input bit dir, input int eat, input int pfrom);
        int t;
        @(negedge clk);
        desc_src_i = s; desc_dst_i = d; desc_len_i = LW'(len); desc_dir_i = dir;
        exp_src = s; exp_dst = d; exp_len = len; exp_dir = dir;
        fills = 0; drains = 0; quiet = 0; err_at = eat; run_cyc = 0; pause_from = pfrom;
        desc_set_i = 1'b1;
        mon_on = 1;
        @(negedge clk);
        desc_set_i = 1'b0;
        chk(desc_valid_o && dbg_state_o == 3'd0, "R2 flag raised while idle", desc_valid_o, 1);
        @(negedge clk);
        chk(dbg_state_o == 3'd1, "R3 load state entered", dbg_state_o, 1);
        chk(!desc_valid_o, "R3 flag cleared on load", desc_valid_o, 0);
        chk(stat_busy_o && !stat_done_o && !stat_err_o, "R3 status cleared and busy",
            {stat_busy_o, stat_done_o, stat_err_o}, 3'b100);
        desc_src_i = $urandom; desc_dst_i = $urandom;
        desc_len_i = LW'($urandom); desc_dir_i = 1'($urandom);
        t = 0;
        while (dbg_state_o != 3'd0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        chk(t < 5000, "R8 transfer reached idle", t, 0);
        if (len == 0) begin
            chk(stat_err_o && !stat_done_o, "R10 zero count reports error", stat_err_o, 1);
            chk(fills == 0 && drains == 0, "R10 zero count issues no beat", fills + drains, 0);
        end else if (eat >= 0) begin
            chk(stat_err_o && !stat_done_o && !stat_busy_o, "R9 error status",
                {stat_err_o, stat_done_o, stat_busy_o}, 3'b100);
            chk(drains == eat, "R9 no write after error", drains, eat);
        end else begin
            chk(stat_done_o && !stat_err_o && !stat_busy_o, "R8 done status",
                {stat_done_o, stat_err_o, stat_busy_o}, 3'b100);
            chk(drains == beats_of(len) && fills == beats_of(len), "R6 beat totals",
                drains, beats_of(len));
            chk(dbg_remain_o == '0, "R8 nothing left", dbg_remain_o, 0);
        end
        mon_on = 0;
        pause_from = -1;
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(dbg_state_o == 3'd0 && !mtx_req_o && !brg_req_o, "R1 idle in reset", dbg_state_o, 0);
        chk(!desc_valid_o && !stat_done_o && !stat_err_o && !stat_busy_o, "R1 flags clear in reset",
            {desc_valid_o, stat_done_o, stat_err_o, stat_busy_o}, 0);
        rst_n = 1'b1;
        desc_src_i = 32'h100; desc_dst_i = 32'h200; desc_len_i = 10'd16;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(dbg_state_o == 3'd0 && !mtx_req_o && !brg_req_o, "R2 idle without ready flag",
                dbg_state_o, 0);
        end
        run_desc(32'h0000_1000, 32'h0000_8000, 16, 1'b1, -1, -1);
        run_desc(32'h0000_2000, 32'h0000_9000, 13, 1'b0, -1, -1);
        run_desc(32'h0000_3000, 32'h0000_A000, 4, 1'b1, -1, -1);
        run_desc(32'h0000_4000, 32'h0000_B000, 0, 1'b0, -1, -1);
        run_desc(32'h0000_5000, 32'h0000_C000, 40, 1'b1, 2, -1);
        run_desc(32'h0000_6000, 32'h0000_D000, 40, 1'b0, 0, -1);
        run_desc(32'h0000_7000, 32'h0000_E000, 64, 1'b0, -1, 5);
        run_desc(32'h0000_7100, 32'h0000_E100, 64, 1'b1, -1, 9);
        for (int k = 0; k < 40; k++) begin
            int len, eat;
            len = 1 + int'($urandom % 200);
            eat = ($urandom % 5 == 0) ? int'($urandom % beats_of(len)) : -1;
            run_desc($urandom & 32'hFFFF_FFFC, $urandom, len, 1'($urandom), eat,
                     ($urandom % 4 == 0) ? int'($urandom % 20) : -1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule